// File: doc/BRIEF.md
# Sectioned Memory Address Translator

This block sits below the last-level cache arbiter and rewrites each memory request's address from the view the cores have of memory into the physical address used by the on-chip interconnect. It holds a small table of sections. Each section has a base, a mask and a physical base. The mask selects the low address bits that pass through. The remaining high bits identify the section, and those high bits are replaced by the physical base.

Requests arrive on a valid/ready channel with an address and an opaque tag, which is carried through unchanged. The result leaves one cycle later on a registered valid/ready channel. If no section claims an address, the address is forwarded unchanged and an unmapped flag is raised alongside it.

The section table is reloaded only by a map update broadcast. The broadcast carries every section at once, so every section changes on the same clock edge and a request never sees a mixture of old and new sections.

Top module: `mem_section_xlate`

## Requirements
- R1: An address `a` belongs to section n when `(a & ~mask_n) == base_n`. A request in section n leaves with `out_addr = (a & mask_n) | phys_n` and `out_unmapped = 0`.
- R2: A section whose mask is zero is disabled and never claims any address, including an address equal to its base.
- R3: When two or more sections claim the same address, the section with the lowest index is used.
- R4: When `upd_valid` is high at a clock edge, all sections are loaded at that edge from `upd_base`, `upd_mask` and `upd_phys`. Section n occupies bits `[n*AW +: AW]` of each of these buses. A request accepted at that same edge is translated with the previous table. Requests accepted at later edges use the new table.
- R5: An address claimed by no section leaves with `out_addr` equal to the input address and `out_unmapped = 1`.
- R6: A request is accepted on an edge where `in_valid` and `in_ready` are both high. Its result appears after that edge, with `out_valid = 1` and `out_tag` equal to the accepted `in_tag`.
- R7: `in_ready = out_ready | ~out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_tag` and `out_unmapped` hold their values.
- R8: After reset, `out_valid` is 0. Section 0 holds `RST_BASE0`, `RST_MASK0` and `RST_PHYS0`, and every other section has base, mask and physical base equal to zero.
- R9: The physical base is merged with a bitwise OR, not an addition. Physical-base bits that fall inside the mask are ORed with the passed-through address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Map update broadcast strobe |
| upd_base | input | NSEC*AW | New base for every section |
| upd_mask | input | NSEC*AW | New mask for every section |
| upd_phys | input | NSEC*AW | New physical base for every section |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | AW | Address in the core-visible space |
| in_tag | input | TW | Passthrough payload |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_addr | output | AW | Translated address, or the input address when unmapped |
| out_tag | output | TW | Payload of the request |
| out_unmapped | output | 1 | No section claimed the address |

## Verification
The bench builds the block with AW = 32, TW = 8 and NSEC = 4. This lets it load a table in which section 3 overlaps section 0, section 2 is disabled, and section 1 has a physical base with a bit inside its mask, so priority, disabled sections and OR merging are all reachable in one table. It picks non-zero reset values for section 0 that differ from every later table. A second reset therefore shows at the ports whether section 0 went back to its reset values and whether the other sections were cleared. Directed cases place a request on the same edge as an update and stall the output to exercise holding.

// File: rtl/mem_section_xlate.sv
module mem_section_xlate #(
  parameter int AW = 32,
  parameter int TW = 8,
  parameter int NSEC = 4,
  parameter logic [AW-1:0] RST_BASE0 = '0,
  parameter logic [AW-1:0] RST_MASK0 = '0,
  parameter logic [AW-1:0] RST_PHYS0 = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [NSEC*AW-1:0] upd_base,
  input  logic [NSEC*AW-1:0] upd_mask,
  input  logic [NSEC*AW-1:0] upd_phys,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AW-1:0]      in_addr,
  input  logic [TW-1:0]      in_tag,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [AW-1:0]      out_addr,
  output logic [TW-1:0]      out_tag,
  output logic               out_unmapped
);

  localparam int MW = NSEC * AW;
  localparam logic [MW-1:0] BASE_RST = MW'(RST_BASE0);
  localparam logic [MW-1:0] MASK_RST = MW'(RST_MASK0);
  localparam logic [MW-1:0] PHYS_RST = MW'(RST_PHYS0);

  logic [MW-1:0] base_q, mask_q, phys_q;
  logic          any_hit;
  logic [AW-1:0] xl_addr;
  logic          take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      mask_q <= MASK_RST;
      phys_q <= PHYS_RST;
    end else if (upd_valid) begin
      base_q <= upd_base;
      mask_q <= upd_mask;
      phys_q <= upd_phys;
    end
  end

  always_comb begin
    any_hit = 1'b0;
    xl_addr = in_addr;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (mask_q[i*AW +: AW] != '0 &&
          (in_addr & ~mask_q[i*AW +: AW]) == base_q[i*AW +: AW]) begin
        any_hit = 1'b1;
        xl_addr = (in_addr & mask_q[i*AW +: AW]) | phys_q[i*AW +: AW];
      end
    end
  end

  assign in_ready = out_ready | ~out_valid;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_tag      <= '0;
      out_unmapped <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_addr     <= xl_addr;
      out_tag      <= in_tag;
      out_unmapped <= ~any_hit;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  assert_map_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(base_q) && $stable(mask_q) && $stable(phys_q)));

  assert_miss_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !any_hit) |=> (out_unmapped && out_addr == $past(in_addr)));

  assert_accept_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_valid && out_tag == $past(in_tag)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_tag) && $stable(out_unmapped)));

  assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/tb_mem_section_xlate.sv
module tb_mem_section_xlate;
  localparam int AW = 32;
  localparam int TW = 8;
  localparam int NSEC = 4;
  localparam int NV = 11;

  localparam logic [31:0] VIN [NV] = '{
    32'h8000_0ABC, 32'h8000_5678, 32'h9012_3456, 32'hA000_0000,
    32'hA000_0010, 32'h9100_0000, 32'h8001_0000, 32'h90FF_FFFF,
    32'h8000_0FFF, 32'h8000_FFFF, 32'h9000_0001};
  localparam logic [31:0] VOUT [NV] = '{
    32'h0002_0ABC, 32'h3000_5678, 32'h1012_3457, 32'hA000_0000,
    32'hA000_0010, 32'h9100_0000, 32'h8001_0000, 32'h10FF_FFFF,
    32'h0002_0FFF, 32'h3000_FFFF, 32'h1000_0001};
  localparam logic VUNM [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 0, rst_n = 0;
  logic upd_valid = 0;
  logic [NSEC*AW-1:0] upd_base = '0, upd_mask = '0, upd_phys = '0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, out_unmapped;
  logic [AW-1:0] in_addr = '0, out_addr;
  logic [TW-1:0] in_tag = '0, out_tag;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_section_xlate #(.AW(AW), .TW(TW), .NSEC(NSEC),
    .RST_BASE0(32'h8000_0000), .RST_MASK0(32'h0000_FFFF), .RST_PHYS0(32'h0010_0000)
  ) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [7:0] t, input bit upd);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_tag = t; upd_valid = upd;
    @(negedge clk);
    in_valid = 0; upd_valid = 0;
  endtask

  task automatic xfer(input string req, input logic [31:0] a, input logic [7:0] t,
                      input logic [31:0] ea, input logic eu);
    send(a, t, 0);
    chk({req, " valid"}, 64'(out_valid), 64'(1'b1));
    chk({req, " addr"}, 64'(out_addr), 64'(ea));
    chk({req, " unmapped"}, 64'(out_unmapped), 64'(eu));
    chk({req, " tag"}, 64'(out_tag), 64'(t));
  endtask

  task automatic load_map(input logic [NSEC*AW-1:0] b, m, p);
    @(negedge clk);
    upd_base = b; upd_mask = m; upd_phys = p; upd_valid = 1;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 out_valid after reset", 64'(out_valid), 64'(1'b0));
    chk("R7 in_ready idle", 64'(in_ready), 64'(1'b1));
    rst_n = 1;
    xfer("R8 sec0 reset map", 32'h8000_1234, 8'h01, 32'h0010_1234, 0);
    xfer("R8 sec1-3 cleared", 32'h9012_3456, 8'h02, 32'h9012_3456, 1);

    load_map({32'h8000_0000, 32'hA000_0000, 32'h9000_0000, 32'h8000_0000},
             {32'h0000_FFFF, 32'h0000_0000, 32'h00FF_FFFF, 32'h0000_0FFF},
             {32'h3000_0000, 32'h2000_0000, 32'h1000_0001, 32'h0002_0000});
    chk("R4 update alone gives no output", 64'(out_valid), 64'(1'b0));

    for (int i = 0; i < NV; i++)
      xfer($sformatf("R1/R2/R3/R5/R9 vector %0d", i), VIN[i], 8'(8'h10 + i), VOUT[i], VUNM[i]);

    // R4: request on the same edge as an update uses the old table
    upd_base = {32'h8000_0000, 32'hA000_0000, 32'h9000_0000, 32'h8000_0000};
    upd_mask = {32'h0000_FFFF, 32'h0000_0000, 32'h00FF_FFFF, 32'h0000_0FFF};
    upd_phys = {32'h3000_0000, 32'h2000_0000, 32'h5000_0000, 32'h0002_0000};
    send(32'h9000_0010, 8'h40, 1);
    chk("R4 same-edge uses old map", 64'(out_addr), 64'h1000_0011);
    xfer("R4 next request uses new map", 32'h9000_0010, 8'h41, 32'h5000_0010, 0);

    // R7 backpressure
    repeat (2) @(negedge clk);
    chk("R6 out_valid drops when idle", 64'(out_valid), 64'(1'b0));
    out_ready = 0; in_valid = 1; in_addr = 32'h9000_0020; in_tag = 8'h50;
    @(negedge clk);
    chk("R7 in_ready low when stalled", 64'(in_ready), 64'(1'b0));
    in_addr = 32'h8000_0005; in_tag = 8'h51;
    @(negedge clk);
    chk("R7 held valid", 64'(out_valid), 64'(1'b1));
    chk("R7 held addr", 64'(out_addr), 64'h5000_0020);
    chk("R7 held tag", 64'(out_tag), 64'h50);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R7 second request after release", 64'(out_addr), 64'h0002_0005);
    chk("R6 second tag", 64'(out_tag), 64'h51);

    // R8 reset again restores section 0 and clears the rest
    rst_n = 0;
    @(negedge clk);
    chk("R8 out_valid cleared", 64'(out_valid), 64'(1'b0));
    rst_n = 1;
    xfer("R8 sec0 restored", 32'h8000_1234, 8'h60, 32'h0010_1234, 0);
    xfer("R8 sec1 cleared", 32'h9000_0010, 8'h61, 32'h9000_0010, 1);
    xfer("R2 zero-mask section, zero address", 32'h0000_0000, 8'h62, 32'h0000_0000, 1);

    finish_up();
  end
endmodule